// File: doc/BRIEF.md
# Multi-Latency Floating-Point Issue Scoreboard

This block decides, one cycle at a time, whether the oldest waiting floating-point instruction may leave the issue stage. The instructions go to five execution units. Each unit has its own fixed result latency and its own minimum spacing between starts. All results return through one register-file write port. The instruction is presented on the input side and held there until the block raises `in_ready`. Because issue is in order, a held instruction stalls everything behind it.

Four hazard tests run in parallel. The first is the start spacing of the target unit. The second is a write-port reservation ring that records, for each future cycle, whether a result is already booked and for which destination register. The third is a write-after-write test against older operations that finish at or after the candidate. The fourth is a read-after-write test against every in-flight producer of either source register. Any one of them holds issue, and the cause is reported as a 4-bit vector. The ring also produces the registered write-back strobe and destination in the cycle each booked result lands. The arithmetic itself is not modelled.

Top module: `fp_issue_sb`

## Requirements
- R1: Operation codes are 0 add/subtract (latency 4), 1 multiply (latency 8), 2 divide (latency 36), 3 negate/absolute (latency 2) and 4 compare (latency 3). An instruction issued in cycle t (`in_valid` and `in_ready` high) produces `wb_valid`=1 with `wb_dst` equal to its destination in cycle t+latency, and in no other cycle.
- R2: Start spacing is 3 for add, 4 for multiply, 35 for divide, 1 for negate and 2 for compare. A unit that started in cycle t raises `stall_why[0]` for an instruction of the same code until cycle t+spacing. Reserved codes 5 to 7 always raise `stall_why[0]` and never issue.
- R3: `stall_why[1]` is high when a result is already booked for cycle t+latency of the presented instruction.
- R4: `stall_why[2]` is high when an in-flight operation with the same destination completes in or after cycle t+latency of the presented instruction.
- R5: `stall_why[3]` is high when an in-flight operation whose result cycle is later than the current cycle writes either source register. A result landing in the current cycle does not block.
- R6: `in_ready` is high exactly when all four bits of `stall_why` are low.
- R7: After reset, no result is pending: `wb_valid` is 0, no stall bit is set, and `in_ready` is 1.
- R8: At most one result is written back in any cycle, so `wb_valid` is a single strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An instruction is presented |
| in_op | input | 3 | Operation code (R1) |
| in_dst | input | REG_W | Destination register |
| in_src1 | input | REG_W | First source register |
| in_src2 | input | REG_W | Second source register |
| in_ready | output | 1 | Instruction may issue this cycle |
| stall_why | output | 4 | Hazards: [0] unit, [1] port, [2] WAW, [3] RAW |
| wb_valid | output | 1 | A result is written this cycle (registered) |
| wb_dst | output | REG_W | Register written this cycle (registered) |

## Verification
The hardest case to reach is a write-after-write hold behind a divide: a two-cycle negate to the same register must wait about 34 cycles, until its own result would follow the divide's. A directed prefix builds this case, then places an add, a dependent multiply and a second divide behind it. Random traffic then runs over a pool of six registers with mostly valid cycles. This keeps port collisions, unit spacing and write-after-write stalls frequent. Every held instruction stays on the inputs, as in-order issue requires.

// File: rtl/fpsb_pkg.sv
package fpsb_pkg;
  localparam int OPW = 3;
  localparam int NUM_UNITS = 5;
  localparam logic [OPW-1:0] OP_ADD = 3'd0;
  localparam logic [OPW-1:0] OP_MUL = 3'd1;
  localparam logic [OPW-1:0] OP_DIV = 3'd2;
  localparam logic [OPW-1:0] OP_UNA = 3'd3;
  localparam logic [OPW-1:0] OP_CMP = 3'd4;

  function automatic int max_of5(int a, int b, int c, int d, int e);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    if (e > m) m = e;
    return m;
  endfunction
endpackage

// File: rtl/fpsb_unit_gate.sv
module fpsb_unit_gate #(
  parameter int SPACING = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic fire,
  output logic busy
);
  localparam int CW = (SPACING < 2) ? 1 : $clog2(SPACING + 1);

  logic [CW-1:0] wait_cnt;

  assign busy = (wait_cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      wait_cnt <= '0;
    end else if (fire) begin
      wait_cnt <= CW'(SPACING - 1);
    end else if (busy) begin
      wait_cnt <= wait_cnt - 1'b1;
    end
  end
endmodule

// File: rtl/fpsb_wb_ring.sv
module fpsb_wb_ring #(
  parameter int DEPTH = 37,
  parameter int LW    = 6,
  parameter int RW    = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          claim,
  input  logic [LW-1:0] q_lat,
  input  logic [RW-1:0] q_dst,
  input  logic [RW-1:0] q_src1,
  input  logic [RW-1:0] q_src2,
  output logic          port_hit,
  output logic          waw_hit,
  output logic          raw_hit,
  output logic          wb_valid,
  output logic [RW-1:0] wb_dst
);
  logic [DEPTH-1:0] slot_v;
  logic [RW-1:0]    slot_d [DEPTH];
  logic [DEPTH-1:0] nxt_v;
  logic [RW-1:0]    nxt_d  [DEPTH];

  for (genvar k = 0; k < DEPTH; k++) begin : g_slot
    logic book;
    assign book = claim && (q_lat == LW'(k + 1));

    if (k == DEPTH - 1) begin : g_top
      assign nxt_v[k] = 1'b0;
      assign nxt_d[k] = '0;
    end else begin : g_mid
      assign nxt_v[k] = slot_v[k+1];
      assign nxt_d[k] = slot_d[k+1];
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        slot_v[k] <= 1'b0;
      end else begin
        slot_v[k] <= nxt_v[k] | book;
      end
      slot_d[k] <= book ? q_dst : nxt_d[k];
    end
  end

  always_comb begin
    port_hit = 1'b0;
    waw_hit  = 1'b0;
    raw_hit  = 1'b0;
    for (int k = 0; k < DEPTH; k++) begin
      if (slot_v[k] && (LW'(k) == q_lat)) port_hit = 1'b1;
      if (slot_v[k] && (slot_d[k] == q_dst) && (LW'(k) >= q_lat)) waw_hit = 1'b1;
      if (slot_v[k] && (k >= 1) && ((slot_d[k] == q_src1) || (slot_d[k] == q_src2)))
        raw_hit = 1'b1;
    end
  end

  assign wb_valid = slot_v[0];
  assign wb_dst   = slot_d[0];
endmodule

// File: rtl/fp_issue_sb.sv
module fp_issue_sb
  import fpsb_pkg::*;
#(
  parameter int REG_W   = 5,
  parameter int LAT_ADD = 4,
  parameter int LAT_MUL = 8,
  parameter int LAT_DIV = 36,
  parameter int LAT_UNA = 2,
  parameter int LAT_CMP = 3,
  parameter int II_ADD  = 3,
  parameter int II_MUL  = 4,
  parameter int II_DIV  = 35,
  parameter int II_UNA  = 1,
  parameter int II_CMP  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [2:0]       in_op,
  input  logic [REG_W-1:0] in_dst,
  input  logic [REG_W-1:0] in_src1,
  input  logic [REG_W-1:0] in_src2,
  output logic             in_ready,
  output logic [3:0]       stall_why,
  output logic             wb_valid,
  output logic [REG_W-1:0] wb_dst
);
  localparam int MAX_LAT = max_of5(LAT_ADD, LAT_MUL, LAT_DIV, LAT_UNA, LAT_CMP);
  localparam int DEPTH   = MAX_LAT + 1;
  localparam int LW      = $clog2(DEPTH + 1);
  localparam int LAT_T [NUM_UNITS] = '{LAT_ADD, LAT_MUL, LAT_DIV, LAT_UNA, LAT_CMP};
  localparam int II_T  [NUM_UNITS] = '{II_ADD, II_MUL, II_DIV, II_UNA, II_CMP};

  logic [NUM_UNITS-1:0] unit_busy;
  logic                 sel_busy;
  logic [LW-1:0]        cur_lat;
  logic                 issue;
  logic                 port_hit, waw_hit, raw_hit;

  assign issue = in_valid && in_ready;

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    fpsb_unit_gate #(.SPACING(II_T[u])) u_gate (
      .clk  (clk),
      .rst  (rst),
      .fire (issue && (in_op == OPW'(u))),
      .busy (unit_busy[u])
    );
  end

  always_comb begin
    sel_busy = 1'b1;
    cur_lat  = LW'(1);
    for (int u = 0; u < NUM_UNITS; u++) begin
      if (in_op == OPW'(u)) begin
        sel_busy = unit_busy[u];
        cur_lat  = LW'(LAT_T[u]);
      end
    end
  end

  fpsb_wb_ring #(.DEPTH(DEPTH), .LW(LW), .RW(REG_W)) u_ring (
    .clk      (clk),
    .rst      (rst),
    .claim    (issue),
    .q_lat    (cur_lat),
    .q_dst    (in_dst),
    .q_src1   (in_src1),
    .q_src2   (in_src2),
    .port_hit (port_hit),
    .waw_hit  (waw_hit),
    .raw_hit  (raw_hit),
    .wb_valid (wb_valid),
    .wb_dst   (wb_dst)
  );

  assign stall_why = {raw_hit, waw_hit, port_hit, sel_busy};
  assign in_ready  = (stall_why == 4'b0000);
endmodule

// File: rtl/fpsb_chk.sv
module fpsb_chk #(
  parameter int RW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [2:0]    in_op,
  input logic [RW-1:0] in_dst,
  input logic [RW-1:0] in_src1,
  input logic [RW-1:0] in_src2,
  input logic          in_ready,
  input logic [3:0]    stall_why,
  input logic          wb_valid,
  input logic [RW-1:0] wb_dst
);
  logic issue;
  assign issue = in_valid && in_ready;

  a_r7_reset_quiet: assert property (@(posedge clk) $past(rst) |-> !wb_valid);

  a_r1_negate_lands: assert property (@(posedge clk) disable iff (rst)
    (issue && in_op == 3'd3) |-> ##2 (wb_valid && wb_dst == $past(in_dst, 2)));

  a_r2_add_spacing: assert property (@(posedge clk) disable iff (rst)
    (issue && in_op == 3'd0) |=> (in_op != 3'd0 || stall_why[0]));

  a_r3_port_clash: assert property (@(posedge clk) disable iff (rst)
    (issue && in_op == 3'd0) |-> ##2 !(in_op == 3'd3 && in_ready));

  a_r4_waw_behind_div: assert property (@(posedge clk) disable iff (rst)
    (issue && in_op == 3'd2) |=> (in_op != 3'd3 || in_dst != $past(in_dst) || stall_why[2]));

  a_r5_raw_next: assert property (@(posedge clk) disable iff (rst)
    issue |=> ((in_src1 != $past(in_dst) && in_src2 != $past(in_dst)) || stall_why[3]));
endmodule

bind fp_issue_sb fpsb_chk #(.RW(REG_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_op     (in_op),
  .in_dst    (in_dst),
  .in_src1   (in_src1),
  .in_src2   (in_src2),
  .in_ready  (in_ready),
  .stall_why (stall_why),
  .wb_valid  (wb_valid),
  .wb_dst    (wb_dst)
);

// File: tb/fp_issue_sb_tb.sv
module fp_issue_sb_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [2:0] in_op = 3'd0;
  logic [4:0] in_dst = '0, in_src1 = '0, in_src2 = '0;
  logic       in_ready;
  logic [3:0] stall_why;
  logic       wb_valid;
  logic [4:0] wb_dst;

  always #2 clk = ~clk;

  fp_issue_sb u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op),
    .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2),
    .in_ready(in_ready), .stall_why(stall_why),
    .wb_valid(wb_valid), .wb_dst(wb_dst)
  );

  int n_run = 0, n_fail = 0, cyc = 0;
  bit done = 0;
  bit hold = 0;
  bit pv [64];
  int pd [64];
  int pc [64];
  int ufree [5];

  function automatic int lat_of(int op);
    case (op)
      0: return 4;
      1: return 8;
      2: return 36;
      3: return 2;
      4: return 3;
      default: return 1;
    endcase
  endfunction

  function automatic int ii_of(int op);
    case (op)
      0: return 3;
      1: return 4;
      2: return 35;
      3: return 1;
      4: return 2;
      default: return 1;
    endcase
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d cycle=%0d", tag, act, exp, cyc);
    end
  endtask

  // one cycle: check write-back, optionally drive, check hazards, update model
  task automatic step(bit use_dir, int d_op, int d_dst, int d_s1, int d_s2, bit allow_rand);
    int exp_wb, exp_d, l, e_unit, e_port, e_waw, e_raw, e_rdy, op;
    @(negedge clk);
    exp_wb = 0; exp_d = 0;
    for (int i = 0; i < 64; i++)
      if (pv[i] && pc[i] == cyc) begin exp_wb++; exp_d = pd[i]; end
    check(exp_wb <= 1, "R8 single port", exp_wb, 1);
    check(wb_valid == (exp_wb != 0), "R1 wb strobe", wb_valid, exp_wb != 0);
    if (exp_wb != 0) check(wb_dst == exp_d, "R1 wb dst", wb_dst, exp_d);
    if (!hold) begin
      if (use_dir) begin
        in_valid = 1'b1; in_op = d_op[2:0]; in_dst = d_dst[4:0];
        in_src1 = d_s1[4:0]; in_src2 = d_s2[4:0];
      end else if (allow_rand) begin
        in_valid = ($urandom % 6) != 0;
        in_op = 3'($urandom % 5);
        in_dst = 5'($urandom % 6);
        in_src1 = 5'($urandom % 6);
        in_src2 = 5'($urandom % 6);
      end else begin
        in_valid = 1'b0;
      end
    end
    #1;
    op = int'(in_op);
    l = lat_of(op);
    e_unit = (op > 4) ? 1 : (cyc < ufree[op]);
    e_port = 0; e_waw = 0; e_raw = 0;
    for (int i = 0; i < 64; i++) begin
      if (pv[i] && pc[i] == cyc + l) e_port = 1;
      if (pv[i] && pd[i] == int'(in_dst) && pc[i] >= cyc + l) e_waw = 1;
      if (pv[i] && pc[i] > cyc && (pd[i] == int'(in_src1) || pd[i] == int'(in_src2))) e_raw = 1;
    end
    e_rdy = !(e_unit || e_port || e_waw || e_raw);
    check(stall_why[0] == e_unit[0], "R2 unit spacing", stall_why[0], e_unit);
    if (op <= 4) begin
      check(stall_why[1] == e_port[0], "R3 port booking", stall_why[1], e_port);
      check(stall_why[2] == e_waw[0], "R4 waw", stall_why[2], e_waw);
      check(stall_why[3] == e_raw[0], "R5 raw", stall_why[3], e_raw);
      check(in_ready == e_rdy[0], "R6 ready", in_ready, e_rdy);
    end else begin
      check(in_ready == 1'b0, "R2 reserved code", in_ready, 0);
    end
    if (in_valid && op <= 4 && e_rdy != 0) begin
      for (int i = 0; i < 64; i++)
        if (!pv[i]) begin pv[i] = 1; pd[i] = int'(in_dst); pc[i] = cyc + l; break; end
      ufree[op] = cyc + ii_of(op);
      hold = 0;
    end else begin
      hold = in_valid;
    end
    for (int i = 0; i < 64; i++) if (pv[i] && pc[i] <= cyc) pv[i] = 0;
    @(posedge clk);
    cyc++;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++;
      n_run++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 64; i++) pv[i] = 0;
    for (int u = 0; u < 5; u++) ufree[u] = 0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(wb_valid == 1'b0, "R7 reset wb", wb_valid, 0);
    rst = 1'b0;
    #1;
    check(in_ready == 1'b1, "R7 ready after reset", in_ready, 1);
    check(stall_why == 4'b0, "R7 no stall after reset", stall_why, 0);
    @(posedge clk);
    cyc = 1;
    // directed: divide then same-destination negate (long WAW hold)
    step(1, 2, 1, 6, 7, 0);
    step(1, 3, 1, 6, 7, 0);
    while (hold) step(0, 0, 0, 0, 0, 0);
    // add, then dependent multiply (RAW), then second divide
    step(1, 0, 2, 3, 4, 0);
    step(1, 1, 3, 2, 5, 0);
    while (hold) step(0, 0, 0, 0, 0, 0);
    step(1, 2, 4, 0, 0, 0);
    while (hold) step(0, 0, 0, 0, 0, 0);
    // add then negate two cycles later (port collision)
    step(1, 0, 5, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    step(1, 3, 0, 5, 5, 0);
    while (hold) step(0, 0, 0, 0, 0, 0);
    // random traffic
    for (int n = 0; n < 4000; n++) step(0, 0, 0, 0, 0, 1);
    while (hold) step(0, 0, 0, 0, 0, 0);
    // reserved code: must never issue (R2)
    step(1, 6, 1, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0);
    hold = 0;
    // drain and confirm every pending result lands
    for (int n = 0; n < 45; n++) step(0, 0, 0, 0, 0, 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule